// File: doc/BRIEF.md
# Offset Calibration and Output Format Unit

This block sits between a 10-bit converter and the sample FIFO that follows it, and it cleans up each raw result before storage. When a calibration is requested, the block asks the converter front end to tie its input to zero. It takes the next conversion result as the measured offset and keeps it in an offset register. From then on, that offset is subtracted from every sample, and the result is clamped so that it cannot wrap.

Raw results arrive in offset-binary form, where code 512 stands for a zero input. The block handles them internally as signed values. A format select then decides whether each corrected result leaves as two's complement or as straight binary. A calibration starts with a one-cycle strobe, which stands for a write of 1 to the offset-mode bit. When the calibration finishes, the block returns to normal conversion without further action.

Top module: `ofc_unit`

## Requirements
- R1: After reset, `out_valid` and `force_zero` are low and the offset register holds zero, so samples pass with no correction.
- R2: A `cal_start` strobe while idle raises `force_zero` in the next cycle. `force_zero` stays high until a raw sample is accepted as the zero-input result.
- R3: The zero-input result produces no `out_valid`. `force_zero` is low in the cycle after that result is accepted.
- R4: The stored offset is the signed value of the zero-input result, which is the raw code with its MSB inverted (code 512 gives 0). Each later sample's signed value has this offset subtracted from it.
- R5: The subtraction saturates at -512 and +511 rather than wrapping.
- R6: With `fmt_bin` = 1 the output is straight binary, meaning the corrected value with its MSB inverted. With `fmt_bin` = 0 it is the corrected value in two's complement. The `fmt_bin` value sampled with the input sample is the one that applies.
- R7: Every raw sample outside a calibration capture gives `out_valid` with its result exactly one cycle later.
- R8: A `cal_start` strobe during a calibration in progress is ignored. No second calibration follows.
- R9: A new calibration replaces the previous offset. The zero-input result is measured raw, with no correction applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| cal_start | input | 1 | One-cycle strobe: offset-mode bit written to 1 |
| fmt_bin | input | 1 | 1 = straight binary output, 0 = two's complement |
| raw_valid | input | 1 | Raw sample strobe from the converter |
| raw_data | input | 10 | Raw offset-binary sample |
| force_zero | output | 1 | Request to the front end to tie the input to zero |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 10 | Corrected, formatted sample |

## Verification
The assertions assume that `cal_start` is a single-cycle strobe. They also assume that, once `force_zero` is high, the converter eventually returns a sample. The bench raises `cal_start` for one cycle only. It delivers the zero-input code only after `force_zero` has been seen high, and it sends no other sample until the calibration has stored its offset. A reference model in the scoreboard applies the signed offset, clamps the result and inverts the MSB, and the scoreboard compares each output against it. The bench includes offsets of both signs, driven into saturation at both ends.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
   typedef enum logic [1:0] {
      CAL_IDLE  = 2'd0,
      CAL_FORCE = 2'd1,
      CAL_WAIT  = 2'd2,
      CAL_STORE = 2'd3
   } cal_state_e;
endpackage

// File: rtl/ofc_cal_seq.sv
module ofc_cal_seq
   import ofc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       raw_valid,
   output cal_state_e state,
   output logic       force_zero,
   output logic       capture,
   output logic       commit
);
   cal_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         CAL_IDLE:  if (start) nxt = CAL_FORCE;
         CAL_FORCE: nxt = CAL_WAIT;
         CAL_WAIT:  if (raw_valid) nxt = CAL_STORE;
         CAL_STORE: nxt = CAL_IDLE;
         default:   nxt = CAL_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= CAL_IDLE;
      else        state <= nxt;
   end

   assign force_zero = (state == CAL_FORCE) || (state == CAL_WAIT);
   assign capture    = (state == CAL_WAIT) && raw_valid;
   assign commit     = (state == CAL_STORE);

   AST_FZ_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == CAL_IDLE) |=> force_zero);                 // R2
   AST_FZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (force_zero && !capture) |=> force_zero);                     // R2
   AST_FZ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !force_zero);                                     // R3
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAL_WAIT) |=> (state == CAL_WAIT || state == CAL_STORE)); // R8
   AST_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (state == CAL_IDLE));                              // R8
endmodule

// File: rtl/ofc_offset_reg.sv
module ofc_offset_reg #(
   parameter int W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic signed [W-1:0] cap_value,
   input  logic                commit,
   output logic signed [W-1:0] offset
);
   logic signed [W-1:0] hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold   <= '0;
         offset <= '0;
      end else begin
         if (capture) hold   <= cap_value;
         if (commit)  offset <= hold;
      end
   end

   AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(offset));                                 // R4
   AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (offset == $past(hold)));                          // R9
endmodule

// File: rtl/ofc_sat_sub.sv
module ofc_sat_sub #(
   parameter int W        = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y
);
   initial begin
      if (W < 2) $error("ofc_sat_sub: W must be at least 2");
   end

   generate
      if (SATURATE) begin : g_sat
         localparam logic signed [W:0] HI = {2'b00, {(W-1){1'b1}}};
         localparam logic signed [W:0] LO = {2'b11, {(W-1){1'b0}}};
         logic signed [W:0] diff;
         always_comb begin
            diff = {a[W-1], a} - {b[W-1], b};
            if (diff > HI)      y = HI[W-1:0];
            else if (diff < LO) y = LO[W-1:0];
            else                y = diff[W-1:0];
         end
      end else begin : g_wrap
         assign y = a - b;
      end
   endgenerate
endmodule

// File: rtl/ofc_unit.sv
module ofc_unit
   import ofc_pkg::*;
#(
   parameter int DATA_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic              fmt_bin,
   input  logic              raw_valid,
   input  logic [DATA_W-1:0] raw_data,
   output logic              force_zero,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int MSB = DATA_W - 1;

   initial begin
      if (DATA_W < 2 || DATA_W > 24) $error("ofc_unit: DATA_W out of range");
   end

   cal_state_e          state;
   logic                capture;
   logic                commit;
   logic signed [MSB:0] raw_signed;
   logic signed [MSB:0] offset;
   logic signed [MSB:0] corr;
   logic [MSB:0]        formatted;

   assign raw_signed = {~raw_data[MSB], raw_data[MSB-1:0]};

   ofc_cal_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cal_start),
      .raw_valid  (raw_valid),
      .state      (state),
      .force_zero (force_zero),
      .capture    (capture),
      .commit     (commit)
   );

   ofc_offset_reg #(.W(DATA_W)) u_ofs (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .cap_value (raw_signed),
      .commit    (commit),
      .offset    (offset)
   );

   ofc_sat_sub #(.W(DATA_W), .SATURATE(SATURATE)) u_sub (
      .a (raw_signed),
      .b (offset),
      .y (corr)
   );

   assign formatted = fmt_bin ? {~corr[MSB], corr[MSB-1:0]} : corr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= raw_valid && !capture;
         if (raw_valid && !capture) out_data <= formatted;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(raw_valid));                              // R7
   AST_CAL_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !out_valid);                                      // R3
   AST_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_valid && !capture) |=> out_valid);                       // R7

   generate
      if (SATURATE) begin : g_chk
         AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
            (!raw_signed[MSB] && offset[MSB]) |-> !corr[MSB]);      // R5
         AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_signed[MSB] && !offset[MSB]) |-> corr[MSB]);       // R5
      end
   endgenerate
endmodule

// File: tb/ofc_unit_test.sv
`timescale 1ns/1ps
module ofc_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cal_start = 1'b0;
   logic       fmt_bin = 1'b0;
   logic       raw_valid = 1'b0;
   logic [9:0] raw_data = '0;
   logic       force_zero;
   logic       out_valid;
   logic [9:0] out_data;

   always #2 clk = ~clk;

   ofc_unit uut (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .fmt_bin(fmt_bin),
      .raw_valid(raw_valid), .raw_data(raw_data), .force_zero(force_zero),
      .out_valid(out_valid), .out_data(out_data)
   );

   int compared = 0;
   int mismatched = 0;
   int model_ofs = 0;
   logic [9:0] exp_q[$];
   string      tag_q[$];

   function automatic logic [9:0] model(input logic [9:0] raw, input logic fb);
      int s, d;
      logic [9:0] r;
      s = int'(raw) - 512;
      d = s - model_ofs;
      if (d > 511)  d = 511;
      if (d < -512) d = -512;
      r = d[9:0];
      if (fb) r[9] = ~r[9];
      return r;
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [9:0] raw, input logic fb, input string tag);
      @(negedge clk);
      raw_valid = 1'b1;
      raw_data  = raw;
      fmt_bin   = fb;
      exp_q.push_back(model(raw, fb));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         raw_valid = 1'b0;
      end
   endtask

   task automatic calibrate(input logic [9:0] code, input logic extra_start);
      @(negedge clk);
      raw_valid = 1'b0;
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      check("R2 force_zero raised", {9'd0, force_zero}, 10'd1);
      @(negedge clk);
      check("R2 force_zero held", {9'd0, force_zero}, 10'd1);
      if (extra_start) cal_start = 1'b1;   // R8 strobe while busy
      @(negedge clk);
      cal_start = 1'b0;
      check("R2 force_zero waits for sample", {9'd0, force_zero}, 10'd1);
      raw_valid = 1'b1;
      raw_data  = code;
      @(negedge clk);
      raw_valid = 1'b0;
      check("R3 force_zero dropped", {9'd0, force_zero}, 10'd0);
      model_ofs = int'(code) - 512;        // R4 R9 raw code, MSB inverted
      @(negedge clk);
      if (extra_start) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 no second calibration", {9'd0, force_zero}, 10'd0);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R3/R7: unexpected out_valid data %h expected none", out_data);
         end else begin
            check(tag_q.pop_front(), out_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      #400000;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid at reset", {9'd0, out_valid}, 10'd0);
      check("R1 force_zero at reset", {9'd0, force_zero}, 10'd0);
      // R1 zero offset, R6 both formats, R7 back-to-back
      send(10'd512, 1'b0, "R1 midscale twos");
      send(10'd0,   1'b0, "R1 min twos");
      send(10'd700, 1'b1, "R6 binary passthrough");
      send(10'd300, 1'b0, "R6 twos negative");
      send(10'd1023, 1'b1, "R6 binary max");
      idle(2);
      // positive offset +8
      calibrate(10'd520, 1'b0);
      send(10'd520, 1'b1, "R4 zero after cal binary");
      send(10'd520, 1'b0, "R4 zero after cal twos");
      send(10'd0,   1'b0, "R5 low saturation");
      send(10'd5,   1'b1, "R5 low saturation binary");
      send(10'd1023, 1'b0, "R4 max minus offset");
      send(10'd600, 1'b0, "R7 stream");
      idle(2);
      // negative offset -12, strobe while busy
      calibrate(10'd500, 1'b1);
      send(10'd1023, 1'b1, "R5 high saturation binary");
      send(10'd1020, 1'b0, "R5 high saturation twos");
      send(10'd500, 1'b0, "R9 replaced offset");
      send(10'd0,   1'b0, "R4 min plus offset");
      idle(2);
      // extreme negative offset
      calibrate(10'd0, 1'b0);
      send(10'd600, 1'b0, "R5 high saturation extreme");
      send(10'd0,   1'b1, "R9 zero after extreme cal");
      idle(4);
      if (exp_q.size() != 0) begin
         compared++;
         mismatched++;
         $display("FAIL R7: %0d results missing expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule